// File: doc/BRIEF.md
# Management Bus Master with Extended-Register Mode

This block runs one transaction at a time on a two-wire PHY management bus. It makes the management clock from the system clock and drives the bidirectional data line through three separate signals: data out, output enable and data in. Each request picks a read or a write and one of two frame layouts.

In standard layout the frame carries a 5-bit PHY address and a 5-bit register address. In extended layout the opcode field is always zero. The PHY-address slot then carries the direction and the three upper bits of an 8-bit register number, which reaches a wider register space inside a single device.

A requester holds `req_valid` for one cycle while `busy` is low. It then waits for the one-cycle `done` pulse. For a read, `rd_data` and `rd_err` are valid from that pulse until the next read finishes.

Top module: `mgmt_bus_master`

## Requirements
- R1: While reset is held, and after it is released, `busy`, `done`, `mdc`, `mdio_oe`, `rd_err` and `rd_data` are all 0.
- R2: Each frame starts with 32 one bits on the data line, followed by the start pair 0 then 1.
- R3: In standard layout (`req_smi`=0), the opcode bits are 1,0 for a read and 0,1 for a write. They are followed by `req_phy[4:0]` and then `req_reg[4:0]`, each MSB first. `req_reg[7:5]` has no effect.
- R4: In extended layout (`req_smi`=1), the opcode is 0,0. The 5-bit address slot carries {`req_read`, 0, `req_reg[7:5]`} MSB first, and the register slot carries `req_reg[4:0]`. `req_phy` has no effect.
- R5: On a write, the turnaround is driven as 1 then 0. Then 16 data bits follow, MSB first. In extended layout the upper 8 data bits are driven as 0, whatever `req_wdata[15:8]` holds.
- R6: On a read, the master drives exactly the first 46 bits of the frame. It releases the line from the first turnaround bit to the end of the frame, so it never drives while the target does.
- R7: On a read, the 16 bits sampled after the turnaround appear MSB first on `rd_data` in the cycle `done` pulses. `done` is high for exactly one cycle per frame.
- R8: `rd_err` is set with `done` on a standard-layout read when the second turnaround bit is sampled as 1. It is 0 for extended-layout reads and for writes.
- R9: `busy` rises in the cycle after acceptance and falls in the cycle `done` is high. A `req_valid` seen while `busy` is high is ignored and does not change the frame in flight.
- R10: `mdc` stays high for `CLK_DIV` system cycles and low for `CLK_DIV` system cycles. The master changes `mdio_o` only in the cycle where `mdc` falls, and it samples `mdio_i` just before `mdc` rises.
- R11: When idle, `mdio_oe` is 0 and `mdc` is held low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when busy is low |
| req_smi | input | 1 | 1 selects extended-register layout |
| req_read | input | 1 | 1 for read, 0 for write |
| req_phy | input | 5 | PHY address (standard layout) |
| req_reg | input | 8 | Register number |
| req_wdata | input | 16 | Write data |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Last read data |
| rd_err | output | 1 | Bad turnaround on standard read |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line input |

## Verification
The bench models a target with a pull-up on the data line. It sweeps every PHY address in standard writes and every value of the upper register bits in both extended reads and extended writes. Each observed 64-bit frame is compared with one built from the field rules.

A design that put the direction flag or the upper register bits in the wrong part of the address slot would produce a frame mismatch. So would one that leaked `req_phy` into an extended frame or drove the upper write byte from the input. Releasing the line one bit late would show up as contention with the target. A bad turnaround bit on an extended read must leave `rd_err` clear, and a request injected mid-frame must leave both the frame and the done count unchanged.

// File: rtl/mgmt_pkg.sv
package mgmt_pkg;
  localparam int PRE_BITS   = 32;
  localparam int HDR_BITS   = 32;
  localparam int FRAME_BITS = PRE_BITS + HDR_BITS;
  localparam int IDX_W      = $clog2(FRAME_BITS);
  // bit index of the first turnaround bit inside the whole frame
  localparam int TA1_IDX    = PRE_BITS + 14;
  localparam int TA2_IDX    = TA1_IDX + 1;
  localparam int DATA_IDX   = TA2_IDX + 1;

  typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} mstate_e;

  typedef struct packed {
    logic        smi;
    logic        rd;
    logic [4:0]  phy;
    logic [7:0]  regn;
    logic [15:0] wdata;
  } mreq_t;
endpackage

// File: rtl/mgmt_clk_div.sv
module mgmt_clk_div #(
  parameter int DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic mdc,
  output logic rise_tick,
  output logic fall_tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic          mdc_q, mdc_d;
  logic          wrap;

  always_comb begin
    wrap      = (cnt_q == CW'(DIV - 1));
    rise_tick = en & wrap & ~mdc_q;
    fall_tick = en & wrap & mdc_q;
    cnt_d     = cnt_q;
    mdc_d     = mdc_q;
    if (!en) begin
      cnt_d = '0;
      mdc_d = 1'b0;
    end else if (wrap) begin
      cnt_d = '0;
      mdc_d = ~mdc_q;
    end else begin
      cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      mdc_q <= mdc_d;
    end
  end

  assign mdc = mdc_q;
endmodule

// File: rtl/mgmt_frame_fmt.sv
module mgmt_frame_fmt
  import mgmt_pkg::*;
(
  input  mreq_t                req,
  output logic [HDR_BITS-1:0]  hdr
);
  logic [1:0]  op;
  logic [4:0]  addr_slot;
  logic [1:0]  ta;
  logic [15:0] data;

  always_comb begin
    if (req.smi) begin
      op        = 2'b00;
      addr_slot = {req.rd, 1'b0, req.regn[7:5]};
      data      = {8'h00, req.wdata[7:0]};
    end else begin
      op        = req.rd ? 2'b10 : 2'b01;
      addr_slot = req.phy;
      data      = req.wdata;
    end
    // on reads these bits are never driven: output enable is off
    ta  = req.rd ? 2'b11 : 2'b10;
    if (req.rd) data = 16'hFFFF;
    hdr = {2'b01, op, addr_slot, req.regn[4:0], ta, data};
  end
endmodule

// File: rtl/mgmt_rx_capture.sv
module mgmt_rx_capture
  import mgmt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sample,
  input  logic             is_read,
  input  logic [IDX_W-1:0] bit_idx,
  input  logic             din,
  output logic [15:0]      data,
  output logic             ta_bit
);
  logic [15:0] data_d;
  logic        ta_d;

  always_comb begin
    data_d = data;
    ta_d   = ta_bit;
    if (sample && is_read) begin
      if (bit_idx == IDX_W'(TA2_IDX)) ta_d = din;
      if (bit_idx >= IDX_W'(DATA_IDX)) data_d = {data[14:0], din};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data   <= '0;
      ta_bit <= 1'b0;
    end else begin
      data   <= data_d;
      ta_bit <= ta_d;
    end
  end
endmodule

// File: rtl/mgmt_bus_master.sv
module mgmt_bus_master
  import mgmt_pkg::*;
#(
  parameter int CLK_DIV = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_smi,
  input  logic        req_read,
  input  logic [4:0]  req_phy,
  input  logic [7:0]  req_reg,
  input  logic [15:0] req_wdata,
  output logic        busy,
  output logic        done,
  output logic [15:0] rd_data,
  output logic        rd_err,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BITS - 1);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  mstate_e               state_q, state_d;
  logic [IDX_W-1:0]      bit_q, bit_d;
  logic [FRAME_BITS-1:0] sh_q, sh_d;
  logic                  oe_q, oe_d;
  logic                  rd_q, rd_d;
  logic                  smi_q, smi_d;
  logic                  done_q, done_d;
  logic [15:0]           rdata_q, rdata_d;
  logic                  err_q, err_d;

  logic                  rise_tick, fall_tick;
  logic [HDR_BITS-1:0]   hdr;
  logic [15:0]           cap_data;
  logic                  cap_ta;
  mreq_t                 req;
  logic                  accept;
  logic [IDX_W:0]        next_idx;

  assign req = '{smi: req_smi, rd: req_read, phy: req_phy,
                 regn: req_reg, wdata: req_wdata};

  mgmt_clk_div #(.DIV(CLK_DIV)) u_div (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .en        (state_q == ST_RUN),
    .mdc       (mdc),
    .rise_tick (rise_tick),
    .fall_tick (fall_tick)
  );

  mgmt_frame_fmt u_fmt (
    .req (req),
    .hdr (hdr)
  );

  mgmt_rx_capture u_rx (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .sample  (rise_tick),
    .is_read (rd_q),
    .bit_idx (bit_q),
    .din     (mdio_i),
    .data    (cap_data),
    .ta_bit  (cap_ta)
  );

  always_comb begin
    state_d  = state_q;
    bit_d    = bit_q;
    sh_d     = sh_q;
    oe_d     = oe_q;
    rd_d     = rd_q;
    smi_d    = smi_q;
    done_d   = 1'b0;
    rdata_d  = rdata_q;
    err_d    = err_q;
    accept   = (state_q == ST_IDLE) && req_valid;
    next_idx = {1'b0, bit_q} + (IDX_W+1)'(1);

    if (accept) begin
      state_d = ST_RUN;
      bit_d   = '0;
      sh_d    = {{PRE_BITS{1'b1}}, hdr};
      oe_d    = 1'b1;
      rd_d    = req_read;
      smi_d   = req_smi;
    end else if (state_q == ST_RUN && fall_tick) begin
      sh_d = {sh_q[FRAME_BITS-2:0], 1'b0};
      if (bit_q == LAST_IDX) begin
        state_d = ST_IDLE;
        oe_d    = 1'b0;
        done_d  = 1'b1;
        if (rd_q) begin
          rdata_d = cap_data;
          err_d   = ~smi_q & cap_ta;
        end else begin
          err_d   = 1'b0;
        end
      end else begin
        bit_d = next_idx[IDX_W-1:0];
        oe_d  = !(rd_q && (next_idx >= (IDX_W+1)'(TA1_IDX)));
      end
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      state_q <= ST_IDLE;
      bit_q   <= '0;
      sh_q    <= '0;
      oe_q    <= 1'b0;
      rd_q    <= 1'b0;
      smi_q   <= 1'b0;
      done_q  <= 1'b0;
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      bit_q   <= bit_d;
      sh_q    <= sh_d;
      oe_q    <= oe_d;
      rd_q    <= rd_d;
      smi_q   <= smi_d;
      done_q  <= done_d;
      rdata_q <= rdata_d;
      err_q   <= err_d;
    end
  end

  assign busy    = (state_q == ST_RUN);
  assign done    = done_q;
  assign rd_data = rdata_q;
  assign rd_err  = err_q;
  assign mdio_o  = sh_q[FRAME_BITS-1];
  assign mdio_oe = oe_q;
endmodule

// File: rtl/mgmt_bus_master_chk.sv
module mgmt_bus_master_chk (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic done,
  input logic mdc,
  input logic mdio_o,
  input logic mdio_oe
);
  // R9: busy only drops together with the done pulse
  a_r9_busy_falls_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  // R9: done only follows a busy frame
  a_r9_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(busy));

  // R7: done is a single-cycle pulse
  a_r7_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R11: idle means line released and clock low
  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mdio_oe && !mdc));

  // R10: output data moves only on the falling management clock
  a_r10_change_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy) && !$stable(mdio_o)) |-> $fell(mdc));
endmodule

bind mgmt_bus_master mgmt_bus_master_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .busy    (busy),
  .done    (done),
  .mdc     (mdc),
  .mdio_o  (mdio_o),
  .mdio_oe (mdio_oe)
);

// File: tb/mgmt_bus_master_tb.sv
module mgmt_bus_master_tb;
  localparam int DIV = 2;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_smi, req_read;
  logic [4:0]  req_phy;
  logic [7:0]  req_reg;
  logic [15:0] req_wdata;
  logic        busy, done, rd_err, mdc, mdio_o, mdio_oe, mdio_i;
  logic [15:0] rd_data;

  always #2 clk = ~clk;

  // target model state
  logic        tgt_oe = 1'b0, tgt_o = 1'b1;
  logic        cur_read = 1'b0, ta_val = 1'b0;
  logic [15:0] resp = '0;
  logic [63:0] cap = '0;
  int          rise_cnt = 0, oe_rises = 0, contention = 0, done_cnt = 0;
  int          hi_run = 0, hp_checks = 0, hp_bad = 0;
  int          total = 0, bad = 0;
  logic        line;

  assign line   = mdio_oe ? mdio_o : (tgt_oe ? tgt_o : 1'b1);
  assign mdio_i = line;

  mgmt_bus_master #(.CLK_DIV(DIV)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_smi(req_smi),
    .req_read(req_read), .req_phy(req_phy), .req_reg(req_reg),
    .req_wdata(req_wdata), .busy(busy), .done(done), .rd_data(rd_data),
    .rd_err(rd_err), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .mdio_i(mdio_i)
  );

  always @(posedge mdc) begin
    cap = {cap[62:0], line};
    rise_cnt++;
    if (mdio_oe) oe_rises++;
    if (mdio_oe && tgt_oe) contention++;
  end

  always @(negedge mdc) begin
    if (cur_read) begin
      if (rise_cnt == 47) begin
        tgt_oe = 1'b1;
        tgt_o  = ta_val;
      end else if (rise_cnt >= 48 && rise_cnt <= 63) begin
        tgt_oe = 1'b1;
        tgt_o  = resp[63 - rise_cnt];
      end else begin
        tgt_oe = 1'b0;
      end
    end else begin
      tgt_oe = 1'b0;
    end
  end

  always @(negedge clk) begin
    if (done) done_cnt++;
    if (mdc) hi_run++;
    else if (hi_run != 0) begin
      hp_checks++;
      if (hi_run != DIV) hp_bad++;
      hi_run = 0;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic run_frame(input bit smi, input bit rd, input logic [4:0] phy,
                           input logic [7:0] regn, input logic [15:0] wdata,
                           input logic [15:0] rsp, input bit tav,
                           input bit inject, input string tag);
    logic [1:0]  op;
    logic [4:0]  slot;
    logic [1:0]  ta;
    logic [15:0] dat;
    logic [63:0] exp;
    int          w;
    rise_cnt = 0; cap = '0; oe_rises = 0; contention = 0; done_cnt = 0;
    cur_read = rd; ta_val = tav; resp = rsp; tgt_oe = 1'b0;
    @(negedge clk);
    req_valid = 1'b1; req_smi = smi; req_read = rd; req_phy = phy;
    req_reg = regn; req_wdata = wdata;
    @(negedge clk);
    req_valid = 1'b0;
    check(busy == 1'b1, "R9", "busy after accept", 64'(busy), 64'd1);
    if (inject) begin
      repeat (40) @(negedge clk);
      req_valid = 1'b1; req_smi = ~smi; req_read = ~rd; req_phy = ~phy;
      req_reg = ~regn; req_wdata = ~wdata;
      @(negedge clk);
      req_valid = 1'b0;
    end
    w = 0;
    while (!done && w < 2000) begin
      @(negedge clk);
      w++;
    end
    check(w < 2000, "R9", "done seen", 64'(w), 64'd0);
    check(busy == 1'b0, "R9", "busy low with done", 64'(busy), 64'd0);
    if (rd) begin
      check(rd_data == rsp, "R7", "read data", 64'(rd_data), 64'(rsp));
      check(rd_err == (!smi && tav), "R8", "error flag", 64'(rd_err),
            64'(!smi && tav));
    end else begin
      check(rd_err == 1'b0, "R8", "error on write", 64'(rd_err), 64'd0);
    end
    @(negedge clk);
    check(done == 1'b0 && done_cnt == 1, "R7", "done pulse count",
          64'(done_cnt), 64'd1);
    check(mdio_oe == 1'b0 && mdc == 1'b0, "R11", "idle line",
          64'({mdio_oe, mdc}), 64'd0);
    op   = smi ? 2'b00 : (rd ? 2'b10 : 2'b01);
    slot = smi ? {rd, 1'b0, regn[7:5]} : phy;
    ta   = rd ? {1'b1, tav} : 2'b10;
    dat  = rd ? rsp : (smi ? {8'h00, wdata[7:0]} : wdata);
    exp  = {32'hFFFF_FFFF, 2'b01, op, slot, regn[4:0], ta, dat};
    check(cap[63:30] == exp[63:30], "R2", "preamble and start",
          64'(cap[63:30]), 64'(exp[63:30]));
    check(cap == exp, tag, "whole frame", cap, exp);
    check(rise_cnt == 64, "R10", "clock count", 64'(rise_cnt), 64'd64);
    check(oe_rises == (rd ? 46 : 64), "R6", "driven bits", 64'(oe_rises),
          64'(rd ? 46 : 64));
    check(contention == 0, "R6", "line contention", 64'(contention), 64'd0);
  endtask

  initial begin
    #(4 * 200000);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_smi = 1'b0; req_read = 1'b0;
    req_phy = '0; req_reg = '0; req_wdata = '0;
    repeat (4) @(negedge clk);
    check({busy, done, mdc, mdio_oe, rd_err} == 5'b0 && rd_data == 16'h0,
          "R1", "state in reset", 64'({busy, done, mdc, mdio_oe, rd_err}), 64'd0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check({busy, done, mdc, mdio_oe} == 4'b0, "R1", "state after release",
          64'({busy, done, mdc, mdio_oe}), 64'd0);

    // R3 standard writes over every PHY address, upper reg bits nonzero
    for (int p = 0; p < 32; p++) begin
      run_frame(1'b0, 1'b0, 5'(p), 8'((p * 37) & 255),
                16'(p * 16'h0813) ^ 16'hA5C3, 16'h0, 1'b0, 1'b0, "R3");
    end
    // R3 R7 standard reads
    for (int k = 0; k < 8; k++) begin
      run_frame(1'b0, 1'b1, 5'(k * 3), 8'(k * 29), 16'h0,
                16'(k * 16'h1357) ^ 16'h8001, 1'b0, 1'b0, "R3");
    end
    // R8 bad turnaround on standard read
    run_frame(1'b0, 1'b1, 5'd7, 8'd12, 16'h0, 16'hBEEF, 1'b1, 1'b0, "R8");
    // R4 R5 extended writes, every upper register value, upper data set
    for (int h = 0; h < 8; h++) begin
      run_frame(1'b1, 1'b0, 5'(31 - h), 8'({3'(h), 5'(h * 5)}),
                16'hFF00 | 16'(h * 17), 16'h0, 1'b0, 1'b0, "R4");
    end
    // R4 R7 extended reads
    for (int h = 0; h < 8; h++) begin
      run_frame(1'b1, 1'b1, 5'(h), 8'({3'(h), 5'(31 - h)}), 16'h0,
                {8'h00, 8'(h * 33 + 1)}, 1'b0, 1'b0, "R4");
    end
    // R8 extended read ignores turnaround value
    run_frame(1'b1, 1'b1, 5'd3, 8'hA5, 16'h0, 16'h005A, 1'b1, 1'b0, "R8");
    // R9 request during busy has no effect
    run_frame(1'b0, 1'b0, 5'd9, 8'd17, 16'h3C3C, 16'h0, 1'b0, 1'b1, "R9");
    run_frame(1'b1, 1'b1, 5'd2, 8'hE1, 16'h0, 16'h00C4, 1'b0, 1'b1, "R9");

    check(hp_bad == 0 && hp_checks > 0, "R10", "high half period",
          64'(hp_bad), 64'd0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule